// File: doc/BRIEF.md
# Triggered Multi-Mode Sample FIFO

This block holds three-axis sample triplets from a sensor front end in a 32-entry circular store. The mode input picks one of four behaviours. Bypass keeps nothing. FIFO mode fills until the store is full. Stream mode keeps the newest 32 samples. Trigger mode keeps a rolling history until a trigger event arrives.

When a trigger event arrives in trigger mode, the history is cut down to the newest `n` samples, where `n` comes from the retain-count input. From then on the store only fills until it is full. A triggered flag is raised. It drives one of two interrupt pins, chosen by a select bit. Later trigger events are ignored until the mode passes through bypass, which re-arms the block and empties the store.

The consumer reads the oldest triplet from the head outputs and pops it with a one-cycle request.

Top module: `trig_sample_fifo`

## Requirements
- R1: The store holds at most 32 triplets, and `fill_count` (6 bits) never exceeds 32.
- R2: While `mode` is 2'b00 (bypass), the store is emptied one cycle later, and pushes and pops have no effect.
- R3: With `mode` 2'b01 (FIFO), a sample is accepted only while fewer than 32 are held. A push into a full store is dropped and leaves the count and the head unchanged.
- R4: With `mode` 2'b10 (stream), a push into a full store discards the oldest triplet, so the head moves to the next-oldest sample and the count stays 32.
- R5: The head outputs show the oldest stored triplet, and each pop removes it, in arrival order. A pop on an empty store has no effect, and `head_valid` is low when the store is empty.
- R6: With `mode` 2'b11 (trigger) before any trigger, the store keeps the newest 32 samples, as in stream mode.
- R7: A trigger event in armed trigger mode keeps the newest min(n, count) samples and discards the older ones. A push or pop in that same cycle is ignored.
- R8: After a trigger, trigger mode accepts samples only while the store is not full, and drops them otherwise.
- R9: Once triggered, further trigger events are ignored, and `triggered` stays high. Only a cycle in bypass clears `triggered` and re-arms the block.
- R10: While `triggered` is high, `int1` is driven when `int_sel` is 0 and `int2` when `int_sel` is 1. Both are low otherwise.
- R11: A push and a pop in the same cycle on a full store are both served. The oldest triplet leaves, the new one is stored, and the count stays 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | 00 bypass, 01 FIFO, 10 stream, 11 trigger |
| keep_n | input | 5 | Number of newest samples retained at a trigger |
| int_sel | input | 1 | Interrupt pin select: 0 selects int1, 1 selects int2 |
| smp_valid | input | 1 | Sample strobe |
| smp_x | input | 16 | X-axis word |
| smp_y | input | 16 | Y-axis word |
| smp_z | input | 16 | Z-axis word |
| trig_evt | input | 1 | Trigger event pulse |
| pop | input | 1 | Remove the head triplet |
| head_x | output | 16 | Oldest stored X word |
| head_y | output | 16 | Oldest stored Y word |
| head_z | output | 16 | Oldest stored Z word |
| head_valid | output | 1 | Store not empty |
| fill_count | output | 6 | Number of stored triplets |
| triggered | output | 1 | Trigger has been taken since the last re-arm |
| int1 | output | 1 | Trigger interrupt, pin 1 |
| int2 | output | 1 | Trigger interrupt, pin 2 |

## Verification
Every push, pop, trigger and mode change is taken at one rising edge. The count, the triggered flag and the head pointer all change at that same edge, so each result is due exactly one cycle after its stimulus. The head data and the interrupt pins follow from the registered state without extra delay. The bench drives inputs on the falling edge and samples on the next falling edge, after exactly one rising edge, so every comparison lands in the cycle where the new state is first visible. Reset release passes through a two-stage synchronizer, and the bench waits for it before the first check.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS  = 2'b00,
    MODE_FIFO    = 2'b01,
    MODE_STREAM  = 2'b10,
    MODE_TRIGGER = 2'b11
  } tsf_mode_e;
endpackage

// File: rtl/tsf_rst_sync.sv
module tsf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tsf_store.sv
module tsf_store #(
  parameter int DEPTH  = 32,
  parameter int WORD_W = 48,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tsf_mode_e        mode,
  input  logic [PTR_W-1:0] keep_n,
  input  logic             smp_valid,
  input  logic             trig_evt,
  input  logic             pop,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             triggered
);
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, keep_cnt;
  logic             trig_q, trig_d;
  logic             in_byp, in_trig, fire, hold_full, full;
  logic             pop_ok, push_ok, drop, state_en;

  always_comb begin
    in_byp    = (mode == MODE_BYPASS);
    in_trig   = (mode == MODE_TRIGGER);
    fire      = in_trig && !trig_q && trig_evt;
    hold_full = (mode == MODE_FIFO) || (in_trig && trig_q);
    full      = (cnt_q == CNT_W'(DEPTH));
    pop_ok    = pop && (cnt_q != '0);
    push_ok   = smp_valid && (!hold_full || !full || pop_ok);
    drop      = push_ok && full && !pop_ok;
    keep_cnt  = (CNT_W'(keep_n) < cnt_q) ? CNT_W'(keep_n) : cnt_q;

    wr_d   = wr_q;
    rd_d   = rd_q;
    cnt_d  = cnt_q;
    trig_d = trig_q;
    wr_en  = 1'b0;

    if (in_byp) begin
      wr_d   = '0;
      rd_d   = '0;
      cnt_d  = '0;
      trig_d = 1'b0;
    end else if (fire) begin
      trig_d = 1'b1;
      cnt_d  = keep_cnt;
      rd_d   = wr_q - keep_cnt[PTR_W-1:0];
    end else begin
      wr_en = push_ok;
      wr_d  = wr_q + PTR_W'(push_ok);
      rd_d  = rd_q + PTR_W'(pop_ok || drop);
      cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok) - CNT_W'(drop);
    end

    state_en = (wr_d != wr_q) || (rd_d != rd_q) || (cnt_d != cnt_q) || (trig_d != trig_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      trig_q <= 1'b0;
    end else if (state_en) begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
      trig_q <= trig_d;
    end
  end

  assign wr_ptr    = wr_q;
  assign rd_ptr    = rd_q;
  assign count     = cnt_q;
  assign triggered = trig_q;

  p_count_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  p_bypass_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_byp |=> (cnt_q == '0) && !trig_q);
  p_fifo_no_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FIFO) && full && !pop |=> cnt_q == CNT_W'(DEPTH));
  p_stream_keep_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STREAM) && full && !pop |=> cnt_q == CNT_W'(DEPTH));
  p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) && !smp_valid |=> cnt_q == '0);
  p_trim_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_q) |-> (cnt_q <= $past(cnt_q)) && (cnt_q <= CNT_W'($past(keep_n))));
  p_armed_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q && !in_byp |=> trig_q);
endmodule

// File: rtl/trig_sample_fifo.sv
module trig_sample_fifo
  import tsf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int AXIS_W = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int WORD_W = 3 * AXIS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [PTR_W-1:0]  keep_n,
  input  logic              int_sel,
  input  logic              smp_valid,
  input  logic [AXIS_W-1:0] smp_x,
  input  logic [AXIS_W-1:0] smp_y,
  input  logic [AXIS_W-1:0] smp_z,
  input  logic              trig_evt,
  input  logic              pop,
  output logic [AXIS_W-1:0] head_x,
  output logic [AXIS_W-1:0] head_y,
  output logic [AXIS_W-1:0] head_z,
  output logic              head_valid,
  output logic [CNT_W-1:0]  fill_count,
  output logic              triggered,
  output logic              int1,
  output logic              int2
);
  logic              rst_n_s, wr_en;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [WORD_W-1:0] rd_word;
  tsf_mode_e         mode_e;

  assign mode_e = tsf_mode_e'(mode);

  tsf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  tsf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .mode(mode_e), .keep_n(keep_n),
    .smp_valid(smp_valid), .trig_evt(trig_evt), .pop(pop),
    .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(fill_count), .triggered(triggered)
  );

  tsf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr),
    .wr_data({smp_x, smp_y, smp_z}), .rd_ptr(rd_ptr), .rd_data(rd_word)
  );

  assign {head_x, head_y, head_z} = rd_word;
  assign head_valid = (fill_count != '0);
  assign int1 = triggered && !int_sel;
  assign int2 = triggered && int_sel;

  p_pin_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0({int1, int2}));
  p_pin_follow_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    triggered |-> (int1 || int2));
endmodule

// File: tb/trig_sample_fifo_tb.sv
module trig_sample_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [4:0]  keep_n;
  logic        int_sel, smp_valid, trig_evt, pop;
  logic [15:0] smp_x, smp_y, smp_z;
  logic [15:0] head_x, head_y, head_z;
  logic        head_valid, triggered, int1, int2;
  logic [5:0]  fill_count;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  trig_sample_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .keep_n(keep_n), .int_sel(int_sel),
    .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .trig_evt(trig_evt), .pop(pop), .head_x(head_x), .head_y(head_y),
    .head_z(head_z), .head_valid(head_valid), .fill_count(fill_count),
    .triggered(triggered), .int1(int1), .int2(int2)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input int v);
    smp_valid = 1'b1;
    smp_x = 16'(v); smp_y = 16'(v + 1000); smp_z = 16'(v + 2000);
    step();
    smp_valid = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1;
    step();
    pop = 1'b0;
  endtask

  task automatic chk_head(input string req, input int v);
    chk(req, "head_x", int'(head_x), v);
    chk(req, "head_y", int'(head_y), v + 1000);
    chk(req, "head_z", int'(head_z), v + 2000);
  endtask

  task automatic set_mode(input logic [1:0] m);
    mode = m;
    step();
  endtask

  task automatic t_reset();
    chk("R1", "count after reset", int'(fill_count), 0);
    chk("R5", "head_valid after reset", int'(head_valid), 0);
    chk("R10", "int pins after reset", int'({int1, int2}), 0);
  endtask

  task automatic t_fifo_mode();
    set_mode(2'b01);
    for (int i = 1; i <= 34; i++) push(i);
    chk("R1", "fifo count capped", int'(fill_count), 32);
    chk_head("R3", 1);
    for (int i = 1; i <= 32; i++) begin
      chk_head("R5", i);
      do_pop();
    end
    chk("R5", "count after drain", int'(fill_count), 0);
    chk("R5", "head_valid empty", int'(head_valid), 0);
    do_pop();
    chk("R5", "pop on empty", int'(fill_count), 0);
  endtask

  task automatic t_simul_full();
    for (int i = 1; i <= 32; i++) push(i);
    smp_valid = 1'b1; smp_x = 16'd50; smp_y = 16'd1050; smp_z = 16'd2050;
    pop = 1'b1;
    step();
    smp_valid = 1'b0; pop = 1'b0;
    chk("R11", "count push+pop full", int'(fill_count), 32);
    chk_head("R11", 2);
  endtask

  task automatic t_bypass();
    set_mode(2'b00);
    chk("R2", "bypass clears", int'(fill_count), 0);
    push(7);
    chk("R2", "push in bypass", int'(fill_count), 0);
    chk("R2", "head_valid bypass", int'(head_valid), 0);
  endtask

  task automatic t_stream();
    set_mode(2'b10);
    for (int i = 1; i <= 40; i++) push(i);
    chk("R4", "stream count", int'(fill_count), 32);
    chk_head("R4", 9);
    do_pop();
    chk_head("R4", 10);
    chk("R4", "stream count after pop", int'(fill_count), 31);
  endtask

  task automatic t_trigger();
    set_mode(2'b00);
    set_mode(2'b11);
    for (int i = 1; i <= 40; i++) push(i);
    chk("R6", "pretrigger count", int'(fill_count), 32);
    chk_head("R6", 9);
    keep_n = 5'd5; int_sel = 1'b1; trig_evt = 1'b1;
    step();
    trig_evt = 1'b0;
    chk("R7", "trim count", int'(fill_count), 5);
    chk_head("R7", 36);
    chk("R9", "triggered set", int'(triggered), 1);
    chk("R10", "int2 driven", int'(int2), 1);
    chk("R10", "int1 quiet", int'(int1), 0);
    for (int i = 100; i <= 130; i++) push(i);
    chk("R8", "post trigger full", int'(fill_count), 32);
    chk_head("R8", 36);
    for (int i = 36; i <= 40; i++) do_pop();
    chk_head("R8", 100);
    chk("R8", "count after pops", int'(fill_count), 27);
    keep_n = 5'd2; trig_evt = 1'b1;
    step();
    trig_evt = 1'b0;
    chk("R9", "second trigger ignored", int'(fill_count), 27);
    chk_head("R9", 100);
    set_mode(2'b00);
    chk("R9", "rearm clears flag", int'(triggered), 0);
    set_mode(2'b11);
    for (int i = 1; i <= 3; i++) push(i);
    keep_n = 5'd10; int_sel = 1'b0; trig_evt = 1'b1;
    step();
    trig_evt = 1'b0;
    chk("R7", "n above count keeps all", int'(fill_count), 3);
    chk_head("R7", 1);
    chk("R10", "int1 driven", int'(int1), 1);
    chk("R10", "int2 quiet", int'(int2), 0);
  endtask

  initial begin
    rst_n = 1'b0; mode = 2'b00; keep_n = '0; int_sel = 1'b0;
    smp_valid = 1'b0; trig_evt = 1'b0; pop = 1'b0;
    smp_x = '0; smp_y = '0; smp_z = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_fifo_mode();
    t_simul_full();
    t_bypass();
    t_stream();
    t_trigger();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule